// File: doc/BRIEF.md
# Ripple Add/Subtract Unit with Signed Overflow

This unit is a purely combinational two's-complement arithmetic stage. A single chain of full-adder cells serves both operations. The mode input selects the operation. When the mode is low, the unit forms `a_i + b_i`. When the mode is high, it forms `a_i - b_i`. It does this by complementing every bit of the second operand through an XOR and by feeding the mode bit into the lowest carry, which adds the missing +1.

The unit drives three outputs: the WIDTH-bit result, the raw carry leaving the top cell, and a flag for signed overflow. The flag is the XOR of the carry entering the sign cell and the carry leaving it. An enclosing datapath uses the carry for unsigned compare or borrow, and uses the overflow flag for signed arithmetic. No clock or state is involved, so results follow the inputs within the ripple delay.

Top module: `addsub_ripple`

## Requirements
- R1: With sub_i = 0, {cout_o, sum_o} equals the unsigned sum a_i + b_i taken over WIDTH+1 bits.
- R2: With sub_i = 1, sum_o equals a_i - b_i modulo 2^WIDTH.
- R3: With sub_i = 0, the second operand enters unmodified, so a_i = 0 gives sum_o = b_i and cout_o = 0. With sub_i = 1, the lowest carry-in is 1, so 0 - 0 gives sum_o = 0 and cout_o = 1.
- R4: A carry raised in bit 0 ripples through every cell: all-ones plus one gives sum_o = 0 and cout_o = 1.
- R5: With sub_i = 1, cout_o is 1 exactly when a_i >= b_i as unsigned numbers, so a value of 1 means no borrow.
- R6: ovf_o is 1 exactly when the true signed result of the selected operation lies outside the range of a WIDTH-bit two's-complement number.
- R7: ovf_o can be 1 only when adding operands whose sign bits are equal, or when subtracting operands whose sign bits differ.
- R8: Whenever ovf_o is 1, the sign bit of sum_o differs from the sign bit of a_i.
- R9: WIDTH is a parameter, and R1, R2, R5 and R6 hold at WIDTH = 8 as they do at the default WIDTH = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | WIDTH | Result, modulo 2^WIDTH |
| cout_o | output | 1 | Carry out of the sign cell, reported raw |
| ovf_o | output | 1 | Signed overflow of the selected operation |

## Verification
The checks in the checker are immediate and combinational. They assume that all inputs carry defined 0/1 values and that the outputs have settled before a check is evaluated. They also assume that a_i, b_i and sub_i do not change while one evaluation is in progress. The stimulus changes inputs only on a rising clock edge of the bench and samples the outputs on the falling edge. Every operand pair drawn is a legal bit pattern, and no width is below two bits, so the sign cell always has a distinct carry entering it.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } cell_out_t;

endpackage

// File: rtl/addsub_fa.sv
module addsub_fa
    import addsub_pkg::*;
(
    input  logic      x_i,
    input  logic      y_i,
    input  logic      cin_i,
    output cell_out_t out_o
);

    logic gen_d;
    logic prop_d;
    cell_out_t res_d;

    always_comb begin
        gen_d     = x_i & y_i;
        prop_d    = x_i ^ y_i;
        res_d.sum   = prop_d ^ cin_i;
        res_d.carry = gen_d | (prop_d & cin_i);
    end

    assign out_o = res_d;

endmodule

// File: rtl/addsub_operand.sv
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_i,
    input  op_e              mode_i,
    output logic [WIDTH-1:0] b_eff_o
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_inv
        assign b_eff_o[k] = b_i[k] ^ (mode_i == OP_SUB);
    end

endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf (
    input  logic c_into_sign_i,
    input  logic c_out_sign_i,
    output logic ovf_o
);

    logic ovf_d;

    always_comb begin
        ovf_d = c_into_sign_i ^ c_out_sign_i;
    end

    assign ovf_o = ovf_d;

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             ovf;
    } result_t;

    op_e              mode_d;
    logic [WIDTH-1:0] b_eff_d;
    logic [WIDTH:0]   carry_d;
    logic [WIDTH-1:0] cell_sum_d;
    logic             ovf_raw_d;
    result_t          res_d;

    assign mode_d     = op_e'(sub_i);
    assign carry_d[0] = sub_i;

    addsub_operand #(.WIDTH(WIDTH)) operand_i (
        .b_i     (b_i),
        .mode_i  (mode_d),
        .b_eff_o (b_eff_d)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        cell_out_t cell_q;
        addsub_fa fa_i (
            .x_i   (a_i[k]),
            .y_i   (b_eff_d[k]),
            .cin_i (carry_d[k]),
            .out_o (cell_q)
        );
        assign cell_sum_d[k]  = cell_q.sum;
        assign carry_d[k+1]   = cell_q.carry;
    end

    addsub_ovf ovf_i (
        .c_into_sign_i (carry_d[MSB]),
        .c_out_sign_i  (carry_d[WIDTH]),
        .ovf_o         (ovf_raw_d)
    );

    always_comb begin
        res_d.sum  = cell_sum_d;
        res_d.cout = carry_d[WIDTH];
        res_d.ovf  = ovf_raw_d;
    end

    assign sum_o  = res_d.sum;
    assign cout_o = res_d.cout;
    assign ovf_o  = res_d.ovf;

endmodule

// File: rtl/addsub_ripple_chk.sv
module addsub_ripple_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]          uadd;
    logic [WIDTH-1:0]        udiff;
    logic signed [WIDTH+1:0] sa;
    logic signed [WIDTH+1:0] sb;
    logic signed [WIDTH+1:0] exact;
    logic                    out_of_range;

    always_comb begin
        uadd  = {1'b0, a_i} + {1'b0, b_i};
        udiff = a_i - b_i;
        sa    = {{2{a_i[MSB]}}, a_i};
        sb    = {{2{b_i[MSB]}}, b_i};
        exact = sub_i ? (sa - sb) : (sa + sb);
        out_of_range = !((exact[WIDTH+1:MSB] == '0) || (exact[WIDTH+1:MSB] == '1));

        if (!sub_i) begin
            AST_ADD_RESULT: assert ({cout_o, sum_o} == uadd) else $error("add result"); // R1
        end
        if (sub_i) begin
            AST_SUB_RESULT: assert (sum_o == udiff) else $error("sub result"); // R2
            AST_NO_BORROW: assert (cout_o == (a_i >= b_i)) else $error("borrow"); // R5
        end
        AST_OVF_RANGE: assert (ovf_o == out_of_range) else $error("ovf range"); // R6
        if (ovf_o) begin
            AST_OVF_SIGNS: assert (sub_i ? (a_i[MSB] != b_i[MSB]) : (a_i[MSB] == b_i[MSB])) else $error("ovf signs"); // R7
            AST_OVF_RESULT_SIGN: assert (sum_o[MSB] != a_i[MSB]) else $error("ovf sign"); // R8
        end
    end

endmodule

bind addsub_ripple addsub_ripple_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/addsub_ripple_tb.sv
module addsub_ripple_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int W8 = 8;
    localparam int NVEC = 14;
    localparam int WATCHDOG = 20000;

    // row: {a, b, sub, sum, cout, ovf}
    localparam logic [14:0] VEC [NVEC] = '{
        {4'h3, 4'h2, 1'b0, 4'h5, 1'b0, 1'b0},  // R1
        {4'hF, 4'h1, 1'b0, 4'h0, 1'b1, 1'b0},  // R4
        {4'h7, 4'h1, 1'b0, 4'h8, 1'b0, 1'b1},  // R6
        {4'h8, 4'h8, 1'b0, 4'h0, 1'b1, 1'b1},  // R6
        {4'hB, 4'h3, 1'b0, 4'hE, 1'b0, 1'b0},  // R1
        {4'h5, 4'h3, 1'b1, 4'h2, 1'b1, 1'b0},  // R2
        {4'h3, 4'h5, 1'b1, 4'hE, 1'b0, 1'b0},  // R5
        {4'h8, 4'h1, 1'b1, 4'h7, 1'b1, 1'b1},  // R6
        {4'h7, 4'hF, 1'b1, 4'h8, 1'b0, 1'b1},  // R8
        {4'h0, 4'h0, 1'b1, 4'h0, 1'b1, 1'b0},  // R3
        {4'h9, 4'h9, 1'b1, 4'h0, 1'b1, 1'b0},  // R5
        {4'h7, 4'h8, 1'b0, 4'hF, 1'b0, 1'b0},  // R7
        {4'h4, 4'hC, 1'b1, 4'h8, 1'b0, 1'b1},  // R7
        {4'hC, 4'h4, 1'b1, 4'h8, 1'b1, 1'b0}   // R7
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0]  a, b, sum;
    logic          sub, cout, ovf;
    logic [W8-1:0] a8, b8, sum8;
    logic          sub8, cout8, ovf8;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_ripple #(.WIDTH(W)) dut_i (
        .a_i(a), .b_i(b), .sub_i(sub), .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
    );

    addsub_ripple #(.WIDTH(W8)) dut8_i (
        .a_i(a8), .b_i(b8), .sub_i(sub8), .sum_o(sum8), .cout_o(cout8), .ovf_o(ovf8)
    );

    function automatic string row_tag(int i);
        case (i)
            0, 4:       return "R1";
            1:          return "R4";
            2, 3, 7:    return "R6";
            5:          return "R2";
            6, 10:      return "R5";
            8:          return "R8";
            9:          return "R3";
            default:    return "R7";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive4(logic [W-1:0] av, logic [W-1:0] bv, logic sv);
        @(posedge clk);
        a = av; b = bv; sub = sv;
        @(negedge clk);
    endtask

    // independent model: {sum, cout, ovf}
    function automatic logic [W+1:0] model4(logic [W-1:0] av, logic [W-1:0] bv, logic sv);
        int ia, ib, ua, ub, ex, ures;
        logic c;
        ua = av; ub = bv;
        ia = av[W-1] ? ua - 16 : ua;
        ib = bv[W-1] ? ub - 16 : ub;
        if (sv) begin
            ures = (ua - ub) & 15; c = (ua >= ub); ex = ia - ib;
        end else begin
            ures = (ua + ub) & 15; c = ((ua + ub) > 15); ex = ia + ib;
        end
        return {ures[W-1:0], c, (ex > 7 || ex < -8)};
    endfunction

    initial begin
        a = '0; b = '0; sub = 1'b0;
        a8 = '0; b8 = '0; sub8 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state after bench reset (R1)
        check("R1 idle sum", sum, 0);
        check("R1 idle cout", cout, 0);
        check("R6 idle ovf", ovf, 0);

        for (int i = 0; i < NVEC; i++) begin
            drive4(VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
            check(row_tag(i), {sum, cout, ovf}, VEC[i][5:0]);
        end

        // R3: add mode passes b unchanged
        for (int k = 0; k < 16; k++) begin
            drive4(4'h0, 4'(k), 1'b0);
            check("R3 pass-through", {sum, cout}, {4'(k), 1'b0});
        end

        // R1 R2 R5 R6: every operand pair in both modes
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    logic [W+1:0] e;
                    e = model4(4'(x), 4'(y), m[0]);
                    drive4(4'(x), 4'(y), m[0]);
                    check(m[0] ? "R2 sub sweep" : "R1 add sweep", sum, e[W+1:2]);
                    check(m[0] ? "R5 carry sweep" : "R1 carry sweep", cout, e[1]);
                    check("R6 ovf sweep", ovf, e[0]);
                    if (ovf) begin
                        check("R7 operand signs", (m[0] ? (x[3] != y[3]) : (x[3] == y[3])), 1);
                        check("R8 result sign", (sum[3] != x[3]), 1);
                    end
                end
            end
        end

        // R9: 8-bit instance
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 256; x += 17) begin
                for (int y = 0; y < 256; y += 13) begin
                    int ia, ib, ex, ures;
                    logic c;
                    ia = (x > 127) ? x - 256 : x;
                    ib = (y > 127) ? y - 256 : y;
                    if (m == 1) begin
                        ures = (x - y) & 255; c = (x >= y); ex = ia - ib;
                    end else begin
                        ures = (x + y) & 255; c = ((x + y) > 255); ex = ia + ib;
                    end
                    @(posedge clk);
                    a8 = 8'(x); b8 = 8'(y); sub8 = m[0];
                    @(negedge clk);
                    check("R9 sum", sum8, ures);
                    check("R9 cout", cout8, c);
                    check("R9 ovf", ovf8, (ex > 127 || ex < -128));
                end
            end
        end
        // R9 corner: 0x7F + 1 and 0x80 - 1
        @(posedge clk); a8 = 8'h7F; b8 = 8'h01; sub8 = 1'b0; @(negedge clk);
        check("R9 max+1", {sum8, cout8, ovf8}, {8'h80, 1'b0, 1'b1});
        @(posedge clk); a8 = 8'h80; b8 = 8'h01; sub8 = 1'b1; @(negedge clk);
        check("R9 min-1", {sum8, cout8, ovf8}, {8'h7F, 1'b1, 1'b1});

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule